// File: doc/BRIEF.md
# Address-Space Request Demultiplexer

This block sits between one load/store requester and two memory targets: a local scratchpad and a data cache. Every request carries a two-bit address-space code. Requests coded as shared go to the scratchpad. Every other code goes to the cache. The target is picked from this code alone; the address is never decoded. Requests pass through a pipeline whose depth is set by a parameter. A request stays at the input until the pipeline can move.

In the other direction, the block merges the response streams of the two targets into one registered return port. When both targets offer a response in the same cycle, the scratchpad response goes first and the cache response is held. The response path never waits on the request path. Every port uses a valid/ready handshake. The request payload and its space code go out on one shared bus, and each target has its own valid and ready.

Top module: `aspace_demux`

## Requirements
- R1: The space code `in_space` is decoded as 2'b00 global, 2'b01 shared, 2'b10 IO, and 2'b11 is reserved. Shared requests raise `sp_req_valid`. Every other code, the reserved one included, raises `dc_req_valid`. The two request valids are never high together.
- R2: A forwarded request carries the address, write flag, space code, tag, core id and unique id exactly as they were accepted.
- R3: When both targets stay ready, a request accepted in cycle c shows its target valid in cycle c+REQ_LAT. The default REQ_LAT is 2 and the minimum is 1.
- R4: While the oldest request waits on a target whose ready is low, `in_ready` stays low. The waiting request and its payload do not change. No request is lost or duplicated.
- R5: At most one request is accepted per cycle. Requests reach their targets in the order they were accepted, and back-to-back requests are accepted in consecutive cycles.
- R6: A response accepted from either target appears on `rsp_valid` one cycle later, with its tag, core id and unique id unchanged.
- R7: When both targets present a response in the same cycle, the scratchpad response is accepted and `dc_rsp_ready` is low. The cache response is accepted in a later cycle.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response output holds its value and both response readies are low. Responses still flow while the request path is stalled.
- R9: Reset, active low, clears the pipeline and all output valids.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Incoming request accepted |
| in_addr | input | ADDR_W | Request address |
| in_write | input | 1 | Request is a write |
| in_space | input | 2 | Address-space code |
| in_tag | input | TAG_W | Request tag |
| in_cid | input | CID_W | Core id |
| in_uid | input | UID_W | Unique id |
| sp_req_valid | output | 1 | Request valid toward the scratchpad |
| sp_req_ready | input | 1 | Scratchpad can take a request |
| dc_req_valid | output | 1 | Request valid toward the cache |
| dc_req_ready | input | 1 | Cache can take a request |
| req_addr | output | ADDR_W | Forwarded address (shared bus) |
| req_write | output | 1 | Forwarded write flag |
| req_space | output | 2 | Forwarded space code |
| req_tag | output | TAG_W | Forwarded tag |
| req_cid | output | CID_W | Forwarded core id |
| req_uid | output | UID_W | Forwarded unique id |
| sp_rsp_valid | input | 1 | Scratchpad response valid |
| sp_rsp_ready | output | 1 | Scratchpad response accepted |
| sp_rsp_tag | input | TAG_W | Scratchpad response tag |
| sp_rsp_cid | input | CID_W | Scratchpad response core id |
| sp_rsp_uid | input | UID_W | Scratchpad response unique id |
| dc_rsp_valid | input | 1 | Cache response valid |
| dc_rsp_ready | output | 1 | Cache response accepted |
| dc_rsp_tag | input | TAG_W | Cache response tag |
| dc_rsp_cid | input | CID_W | Cache response core id |
| dc_rsp_uid | input | UID_W | Cache response unique id |
| rsp_valid | output | 1 | Merged response valid |
| rsp_ready | input | 1 | Merged response taken |
| rsp_tag | output | TAG_W | Merged response tag |
| rsp_cid | output | CID_W | Merged response core id |
| rsp_uid | output | UID_W | Merged response unique id |

## Verification
The hardest situation to reach is a request pipeline that is completely full behind a stalled scratchpad while responses keep moving on the other side. To get there, the stimulus holds the scratchpad ready low and pushes three shared requests, so the third one waits at the input. It then checks that `in_ready` stays low and the head payload stays frozen, and meanwhile pushes a cache response through. A forked pair of response drivers raises both response valids on the same edge to exercise the merge priority. A final phase randomises the readies and the space codes, including the reserved code.

// File: rtl/aspace_demux.sv
module aspace_demux #(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 8,
  parameter int CID_W   = 4,
  parameter int UID_W   = 16,
  parameter int REQ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic [1:0]        in_space,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [CID_W-1:0]  in_cid,
  input  logic [UID_W-1:0]  in_uid,
  output logic              sp_req_valid,
  input  logic              sp_req_ready,
  output logic              dc_req_valid,
  input  logic              dc_req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  output logic [1:0]        req_space,
  output logic [TAG_W-1:0]  req_tag,
  output logic [CID_W-1:0]  req_cid,
  output logic [UID_W-1:0]  req_uid,
  input  logic              sp_rsp_valid,
  output logic              sp_rsp_ready,
  input  logic [TAG_W-1:0]  sp_rsp_tag,
  input  logic [CID_W-1:0]  sp_rsp_cid,
  input  logic [UID_W-1:0]  sp_rsp_uid,
  input  logic              dc_rsp_valid,
  output logic              dc_rsp_ready,
  input  logic [TAG_W-1:0]  dc_rsp_tag,
  input  logic [CID_W-1:0]  dc_rsp_cid,
  input  logic [UID_W-1:0]  dc_rsp_uid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [CID_W-1:0]  rsp_cid,
  output logic [UID_W-1:0]  rsp_uid
);

  localparam int PW   = ADDR_W + 1 + 2 + TAG_W + CID_W + UID_W;
  localparam int LAST = REQ_LAT - 1;
  localparam int RW   = TAG_W + CID_W + UID_W;
  localparam logic [1:0] SPACE_SHARED = 2'b01;

  logic [REQ_LAT-1:0] pv;
  logic [PW-1:0]      pd [REQ_LAT];
  logic               head_sh, head_ready, adv;

  assign {req_addr, req_write, req_space, req_tag, req_cid, req_uid} = pd[LAST];
  assign head_sh      = (req_space == SPACE_SHARED);
  assign sp_req_valid = pv[LAST] & head_sh;
  assign dc_req_valid = pv[LAST] & ~head_sh;
  assign head_ready   = head_sh ? sp_req_ready : dc_req_ready;
  assign adv          = ~pv[LAST] | head_ready;
  assign in_ready     = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < REQ_LAT; i++) pd[i] <= '0;
    end else if (adv) begin
      pv[0] <= in_valid;
      pd[0] <= {in_addr, in_write, in_space, in_tag, in_cid, in_uid};
      for (int i = 1; i < REQ_LAT; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  logic          rv, radv;
  logic [RW-1:0] rd;

  assign radv         = ~rv | rsp_ready;
  assign sp_rsp_ready = radv;
  assign dc_rsp_ready = radv & ~sp_rsp_valid;
  assign rsp_valid    = rv;
  assign {rsp_tag, rsp_cid, rsp_uid} = rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv <= 1'b0;
      rd <= '0;
    end else if (radv) begin
      rv <= sp_rsp_valid | dc_rsp_valid;
      rd <= sp_rsp_valid ? {sp_rsp_tag, sp_rsp_cid, sp_rsp_uid}
                         : {dc_rsp_tag, dc_rsp_cid, dc_rsp_uid};
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_req_valid && dc_req_valid)) else $error("two targets");  // R1

  AST_SP_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_req_valid && !sp_req_ready) |=> (sp_req_valid && $stable(req_uid) && $stable(req_addr))) else $error("sp hold");  // R4

  AST_DC_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_req_valid && !dc_req_ready) |=> (dc_req_valid && $stable(req_uid) && $stable(req_addr))) else $error("dc hold");  // R4

  AST_SP_RSP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_rsp_valid && sp_rsp_ready) |=> (rsp_valid && rsp_uid == $past(sp_rsp_uid))) else $error("sp rsp");  // R6

  AST_DC_RSP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_rsp_valid && dc_rsp_ready) |=> (rsp_valid && rsp_uid == $past(dc_rsp_uid))) else $error("dc rsp");  // R6

  AST_SP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_rsp_valid && dc_rsp_valid) |-> !dc_rsp_ready) else $error("prio");  // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_uid) && $stable(rsp_tag))) else $error("rsp hold");  // R8

endmodule

// File: tb/aspace_demux_tb_top.sv
module aspace_demux_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, TAG_W = 8, CID_W = 4, UID_W = 16, REQ_LAT = 2;
  localparam int PW = ADDR_W + 1 + 2 + TAG_W + CID_W + UID_W;
  localparam int RW = TAG_W + CID_W + UID_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, in_write = 0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [1:0] in_space = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [CID_W-1:0] in_cid = '0;
  logic [UID_W-1:0] in_uid = '0;
  logic sp_req_valid, dc_req_valid, sp_req_ready = 1, dc_req_ready = 1;
  logic [ADDR_W-1:0] req_addr;
  logic req_write;
  logic [1:0] req_space;
  logic [TAG_W-1:0] req_tag;
  logic [CID_W-1:0] req_cid;
  logic [UID_W-1:0] req_uid;
  logic sp_rsp_valid = 0, sp_rsp_ready, dc_rsp_valid = 0, dc_rsp_ready;
  logic [TAG_W-1:0] sp_rsp_tag = '0, dc_rsp_tag = '0, rsp_tag;
  logic [CID_W-1:0] sp_rsp_cid = '0, dc_rsp_cid = '0, rsp_cid;
  logic [UID_W-1:0] sp_rsp_uid = '0, dc_rsp_uid = '0, rsp_uid;
  logic rsp_valid, rsp_ready = 1;

  int checks = 0, errors = 0, cyc = 0;
  bit rand_en = 0, done = 0;
  logic [PW-1:0] exp_sp[$], exp_dc[$];
  logic [RW-1:0] exp_rsp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aspace_demux #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CID_W(CID_W), .UID_W(UID_W), .REQ_LAT(REQ_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_write(in_write), .in_space(in_space), .in_tag(in_tag), .in_cid(in_cid), .in_uid(in_uid),
    .sp_req_valid(sp_req_valid), .sp_req_ready(sp_req_ready), .dc_req_valid(dc_req_valid),
    .dc_req_ready(dc_req_ready), .req_addr(req_addr), .req_write(req_write), .req_space(req_space),
    .req_tag(req_tag), .req_cid(req_cid), .req_uid(req_uid),
    .sp_rsp_valid(sp_rsp_valid), .sp_rsp_ready(sp_rsp_ready), .sp_rsp_tag(sp_rsp_tag),
    .sp_rsp_cid(sp_rsp_cid), .sp_rsp_uid(sp_rsp_uid),
    .dc_rsp_valid(dc_rsp_valid), .dc_rsp_ready(dc_rsp_ready), .dc_rsp_tag(dc_rsp_tag),
    .dc_rsp_cid(dc_rsp_cid), .dc_rsp_uid(dc_rsp_uid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_cid(rsp_cid), .rsp_uid(rsp_uid));

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !done) begin
      errors++;
      $display("FAIL R4 watchdog: cycles=%0d expected<=%0d", cyc, 60000);
      summary();
    end
    if (rand_en) begin
      #1;
      sp_req_ready = ($urandom_range(0, 3) != 0);
      dc_req_ready = ($urandom_range(0, 3) != 0);
      rsp_ready    = ($urandom_range(0, 2) != 0);
    end
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    logic [PW-1:0] got, e;
    logic [RW-1:0] rg, re;
    got = {req_addr, req_write, req_space, req_tag, req_cid, req_uid};
    if (sp_req_valid && dc_req_valid) chk(0, "R1 both request valids", 3, 1);
    if (sp_req_valid && sp_req_ready) begin
      if (exp_sp.size() == 0) chk(0, "R4 unexpected scratchpad request uid", req_uid, 0);
      else begin e = exp_sp.pop_front(); chk(got == e, "R1/R2/R5 scratchpad request", got, e); end
    end
    if (dc_req_valid && dc_req_ready) begin
      if (exp_dc.size() == 0) chk(0, "R4 unexpected cache request uid", req_uid, 0);
      else begin e = exp_dc.pop_front(); chk(got == e, "R1/R2/R5 cache request", got, e); end
    end
    if (sp_rsp_valid && sp_rsp_ready) exp_rsp.push_back({sp_rsp_tag, sp_rsp_cid, sp_rsp_uid});
    else if (dc_rsp_valid && dc_rsp_ready) exp_rsp.push_back({dc_rsp_tag, dc_rsp_cid, dc_rsp_uid});
    if (rsp_valid && rsp_ready) begin
      rg = {rsp_tag, rsp_cid, rsp_uid};
      if (exp_rsp.size() == 0) chk(0, "R6 unexpected response uid", rsp_uid, 0);
      else begin re = exp_rsp.pop_front(); chk(rg == re, "R6/R7 merged response", rg, re); end
    end
  end

  task automatic send(input logic [1:0] sp, input logic [UID_W-1:0] uid);
    in_valid = 1; in_space = sp; in_uid = uid;
    in_addr = {uid, ~uid}; in_write = uid[0]; in_tag = uid[TAG_W-1:0] ^ 8'h5a; in_cid = uid[CID_W-1:0];
    if (sp == 2'b01) exp_sp.push_back({in_addr, in_write, in_space, in_tag, in_cid, in_uid});
    else             exp_dc.push_back({in_addr, in_write, in_space, in_tag, in_cid, in_uid});
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic sp_resp(input logic [UID_W-1:0] uid);
    sp_rsp_valid = 1; sp_rsp_uid = uid; sp_rsp_tag = uid[TAG_W-1:0]; sp_rsp_cid = 4'h3;
    forever begin @(negedge clk); if (sp_rsp_ready) break; end
    @(posedge clk); #1;
    sp_rsp_valid = 0;
  endtask

  task automatic dc_resp(input logic [UID_W-1:0] uid);
    dc_rsp_valid = 1; dc_rsp_uid = uid; dc_rsp_tag = uid[TAG_W-1:0]; dc_rsp_cid = 4'hc;
    forever begin @(negedge clk); if (dc_rsp_ready) break; end
    @(posedge clk); #1;
    dc_rsp_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (exp_sp.size() == 0 && exp_dc.size() == 0 && exp_rsp.size() == 0) break;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!sp_req_valid && !dc_req_valid && !rsp_valid, "R9 valids low in reset",
        {sp_req_valid, dc_req_valid, rsp_valid}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(posedge clk); #1;

    // R3 latency with ready targets
    send(2'b01, 16'h0101);
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); n++; if (sp_req_valid) break; end
    chk(n == REQ_LAT, "R3 scratchpad latency", n, REQ_LAT);
    @(posedge clk); #1;
    send(2'b00, 16'h0200);
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); n++; if (dc_req_valid) break; end
    chk(n == REQ_LAT, "R3 cache latency", n, REQ_LAT);
    @(posedge clk); #1;

    // R1 every code, R5 back-to-back
    send(2'b10, 16'h0302); send(2'b11, 16'h0403); send(2'b01, 16'h0501); send(2'b00, 16'h0600);
    drain();
    chk(exp_sp.size() == 0 && exp_dc.size() == 0, "R5 all routed", exp_sp.size() + exp_dc.size(), 0);

    // R4 stall: fill pipeline behind blocked scratchpad
    sp_req_ready = 0;
    send(2'b01, 16'h0a01); send(2'b01, 16'h0b01);
    fork send(2'b01, 16'h0c01); join_none
    repeat (2) @(negedge clk);
    chk(in_ready == 0, "R4 in_ready low while stalled", in_ready, 0);
    chk(sp_req_valid && req_uid == 16'h0a01, "R4 head held", req_uid, 16'h0a01);
    @(posedge clk); #1;
    dc_resp(16'h0d0d);  // R8 responses flow while requests stall
    @(negedge clk);
    chk(rsp_valid && rsp_uid == 16'h0d0d, "R8 response during request stall", rsp_uid, 16'h0d0d);
    chk(req_uid == 16'h0a01 && in_ready == 0, "R4 head still held", req_uid, 16'h0a01);
    @(posedge clk); #1;
    sp_req_ready = 1;
    drain();
    chk(exp_sp.size() == 0, "R4 no request lost", exp_sp.size(), 0);

    // R6 one-cycle response latency
    sp_resp(16'h1111);
    @(negedge clk);
    chk(rsp_valid && rsp_uid == 16'h1111, "R6 scratchpad response next cycle", rsp_uid, 16'h1111);
    @(posedge clk); #1;
    dc_resp(16'h2222);
    @(negedge clk);
    chk(rsp_valid && rsp_uid == 16'h2222, "R6 cache response next cycle", rsp_uid, 16'h2222);
    @(posedge clk); #1;

    // R7 simultaneous responses
    fork sp_resp(16'h3333); dc_resp(16'h4444); join_none
    @(negedge clk);
    chk(sp_rsp_ready && !dc_rsp_ready, "R7 scratchpad wins", {sp_rsp_ready, dc_rsp_ready}, 2'b10);
    @(negedge clk);
    chk(rsp_uid == 16'h3333, "R7 scratchpad response first", rsp_uid, 16'h3333);
    @(negedge clk);
    chk(rsp_uid == 16'h4444, "R7 cache response next", rsp_uid, 16'h4444);
    @(posedge clk); #1;
    drain();

    // R8 output hold under back-pressure
    rsp_ready = 0;
    sp_resp(16'h5555);
    fork sp_resp(16'h6666); join_none
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_uid == 16'h5555, "R8 response held", rsp_uid, 16'h5555);
    chk(!sp_rsp_ready && !dc_rsp_ready, "R8 readies low", {sp_rsp_ready, dc_rsp_ready}, 0);
    @(posedge clk); #1;
    rsp_ready = 1;
    drain();

    // random mix
    rand_en = 1;
    fork
      for (int i = 0; i < 60; i++) send(2'($urandom_range(0, 3)), 16'(16'h8000 + i));
      for (int i = 0; i < 15; i++) sp_resp(16'(16'h9000 + i));
      for (int i = 0; i < 15; i++) dc_resp(16'(16'ha000 + i));
    join
    @(posedge clk); rand_en = 0; #2;
    sp_req_ready = 1; dc_req_ready = 1; rsp_ready = 1;
    drain();
    chk(exp_sp.size() + exp_dc.size() + exp_rsp.size() == 0, "R5 random mix complete",
        exp_sp.size() + exp_dc.size() + exp_rsp.size(), 0);
    done = 1;
    summary();
  end
endmodule